// File: doc/BRIEF.md
# Multi-CPU Interrupt Source Router

This block collects 32 level-sensitive device interrupt lines and turns them into processor priority levels for up to sixteen processors. Each source bit carries a fixed priority level between 0 and 15 taken from a built-in table. Sources whose level is 0 take no part in routing. The live sources are latched into a pending word every clock. Each pending source that is not disabled raises its level bit on one programmable target processor. Any source of level 15 raises level 15 on every processor. One master bit in the disable word silences all of it.

Software uses a small register window of five 32-bit words. Through it, software reads the pending word and the disable word, clears or sets disable bits, and reads or writes the target processor number. The block outputs one 16-bit level vector per processor, from a register. The per-processor controllers downstream pick the highest level from that vector.

Top module: `irq_router`

## Requirements
- R1: Each source bit i maps to the level in the table 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0 (listed from bit 0 up). A pending, enabled source raises bit `level` of the target's vector. Processor c's vector occupies `cpu_lvl[c*16 +: 16]`.
- R2: The sources mapped to level 0 (bits 23 to 26 and 31) never show as pending and never raise any output bit. Bit 0 of every vector is always 0.
- R3: The pending bit of a live source follows the line level: high sets it and low clears it. A read of byte offset 0x00 returns the pending word with bit 31 as 0.
- R4: A read of offset 0x04 returns the disable word ANDed with 0xF05DFF80.
- R5: A write to offset 0x08 clears the disable bits given in the data. A write to offset 0x0C sets them. Both writes are masked by 0xF05DFF80, so the bits of 0x0FA2007F stay disabled.
- R6: Offset 0x10 reads and writes the target processor number. A write keeps only the low 4 bits.
- R7: Only the target processor receives the levels of ordinary sources. Every other processor sees at most bit 15.
- R8: While any source mapped to level 15 (bits 27 to 30) is high, bit 15 is set on every processor. The per-source disable bits do not affect this.
- R9: While bit 31 of the disable word (the master disable) is set, every processor's vector is zero.
- R10: After reset, the disable word is 0x0FA2007F, the pending word is 0, the target is 0, and all vectors are zero.
- R11: An access counts only with all four byte enables and an aligned offset below 0x14. Any other access reads zero and a write of that kind changes nothing.
- R12: A change of state by a register write shows on the vectors one clock later. A source change shows two clocks later (one to latch, one to register the output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 32 | Device interrupt lines, level-sensitive, synchronous to clk |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read access, otherwise 0 |
| cpu_lvl | output | 256 | Registered level vectors, 16 bits per processor |

## Verification
Single sources from several table regions are raised one at a time, then in pairs. This shows whether each bit lands on its own table level and whether levels combine by OR. Retargeting the same source moves its level from one processor to another, which separates target routing from broadcast. A level-15 source is then raised, first enabled and then disabled, and the master disable is toggled. These patterns separate the broadcast path from the disable-gated path. Partial, misaligned and out-of-window accesses are mixed with valid ones to show that only valid accesses change state.

// File: rtl/irq_rt_pkg.sv
// Package: shared constants and the source-to-level table of the router.
// Assumes 32 sources and 16 priority levels, both fixed by the table.
package irq_rt_pkg;

    localparam int SRC_N  = 32;
    localparam int LVL_N  = 16;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int WORD_N = 5;

    // Disable bits that software can never change; reset value of the word.
    localparam logic [SRC_N-1:0] FIXED_DIS = 32'h0fa2_007f;
    localparam logic [SRC_N-1:0] WR_MASK   = ~FIXED_DIS;
    localparam int               MASTER_BIT = 31;

    typedef enum logic [2:0] {
        RW_PEND   = 3'd0,
        RW_DIS    = 3'd1,
        RW_UNMASK = 3'd2,
        RW_MASK   = 3'd3,
        RW_TARGET = 3'd4
    } reg_word_e;

    // Fixed priority level of each source bit.
    function automatic logic [LVL_W-1:0] src_level(input logic [4:0] idx);
        case (idx)
            5'd0,  5'd7:                     src_level = 4'd2;
            5'd1,  5'd8:                     src_level = 4'd3;
            5'd2,  5'd9:                     src_level = 4'd5;
            5'd3,  5'd10:                    src_level = 4'd7;
            5'd4,  5'd11, 5'd21:             src_level = 4'd9;
            5'd5,  5'd12, 5'd22:             src_level = 4'd11;
            5'd6,  5'd13, 5'd17:             src_level = 4'd13;
            5'd14, 5'd15:                    src_level = 4'd12;
            5'd16:                           src_level = 4'd6;
            5'd18:                           src_level = 4'd4;
            5'd19:                           src_level = 4'd10;
            5'd20:                           src_level = 4'd8;
            5'd27, 5'd28, 5'd29, 5'd30:      src_level = 4'd15;
            default:                         src_level = 4'd0;
        endcase
    endfunction

    // Sources that take part in routing (level other than 0).
    function automatic logic [SRC_N-1:0] live_mask();
        logic [SRC_N-1:0] m;
        for (int i = 0; i < SRC_N; i++)
            m[i] = (src_level(5'(i)) != '0);
        return m;
    endfunction

    // Sources whose level is the top one (broadcast to all processors).
    function automatic logic [SRC_N-1:0] top_mask();
        logic [SRC_N-1:0] m;
        for (int i = 0; i < SRC_N; i++)
            m[i] = (src_level(5'(i)) == 4'(LVL_N - 1));
        return m;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
// Module: latches the device lines into the pending word each clock.
// Assumes the lines are already synchronous to clk; dead sources stay 0.
module irq_src_latch
    import irq_rt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_in,
    output logic [SRC_N-1:0] pend_q
);

    localparam logic [SRC_N-1:0] LIVE = live_mask();

    // Pending word tracks the level of every live source.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_in & LIVE;
    end

    // R2
    dead_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(src_in) != $past(src_in) || (pend_q & ~LIVE) == '0);

endmodule

// File: rtl/irq_ctl_regs.sv
// Module: register window holding the disable word and the target number.
// Assumes one-cycle accesses; only full-word aligned accesses below the
// window end are acted on, anything else reads zero and is dropped.
module irq_ctl_regs
    import irq_rt_pkg::*;
#(
    parameter int NCPU   = 16,
    parameter int ADDR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [3:0]              be,
    input  logic [SRC_N-1:0]        wdata,
    input  logic [SRC_N-1:0]        pend_q,
    output logic [SRC_N-1:0]        rdata,
    output logic [SRC_N-1:0]        dis_q,
    output logic [$clog2(NCPU)-1:0] tgt_q
);

    localparam int TGT_W = $clog2(NCPU);

    logic       acc_ok;
    logic [2:0] word;

    // Decode a valid full-word access inside the window.
    always_comb begin
        word   = addr[4:2];
        acc_ok = req && (be == 4'hf) && (addr[1:0] == 2'b00) &&
                 (int'(word) < WORD_N);
    end

    // Disable word: clear on the unmask word, set on the mask word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dis_q <= FIXED_DIS;
        else if (acc_ok && we && word == RW_UNMASK)
            dis_q <= dis_q & ~(wdata & WR_MASK);
        else if (acc_ok && we && word == RW_MASK)
            dis_q <= dis_q | (wdata & WR_MASK);
    end

    // Target processor number, low bits of the write data only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt_q <= '0;
        else if (acc_ok && we && word == RW_TARGET)
            tgt_q <= wdata[TGT_W-1:0];
    end

    // Read multiplexer, zero outside a valid read.
    always_comb begin
        rdata = '0;
        if (acc_ok && !we) begin
            case (word)
                RW_PEND:   rdata = pend_q & ~(SRC_N'(1) << MASTER_BIT);
                RW_DIS:    rdata = dis_q & WR_MASK;
                RW_TARGET: rdata = SRC_N'(tgt_q);
                default:   rdata = '0;
            endcase
        end
    end

    // R5
    fixed_dis_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q & FIXED_DIS) == FIXED_DIS);

    // R6
    tgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && be == 4'hf && addr == ADDR_W'(16)) |=>
        (tgt_q == $past(wdata[TGT_W-1:0])));

    // R11
    bad_acc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (be != 4'hf || addr[1:0] != 2'b00 || addr >= ADDR_W'(20)))
        |=> ($stable(dis_q) && $stable(tgt_q)));

endmodule

// File: rtl/irq_lvl_route.sv
// Module: maps pending, enabled sources to levels and routes them to the
// target processor, broadcasts the top level, and registers the vectors.
// Assumes pend_q, dis_q and tgt_q come from registers of the same clock.
module irq_lvl_route
    import irq_rt_pkg::*;
#(
    parameter int NCPU = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_N-1:0]        pend_q,
    input  logic [SRC_N-1:0]        dis_q,
    input  logic [$clog2(NCPU)-1:0] tgt_q,
    output logic [NCPU*LVL_N-1:0]   lvl_q
);

    localparam int               TGT_W = $clog2(NCPU);
    localparam logic [SRC_N-1:0] TOP   = top_mask();

    logic [LVL_N-1:0]        tgt_vec;
    logic                    top_any;
    logic                    master_off;
    logic [NCPU*LVL_N-1:0]   lvl_nxt;

    // Fold every pending, enabled source onto its level bit.
    always_comb begin
        tgt_vec = '0;
        for (int j = 0; j < SRC_N; j++)
            if (pend_q[j] && !dis_q[j])
                tgt_vec[src_level(5'(j))] = 1'b1;
        tgt_vec[0] = 1'b0;
        top_any    = |(pend_q & TOP);
        master_off = dis_q[MASTER_BIT];
    end

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            // Per-processor vector: target levels plus the top-level broadcast.
            always_comb begin
                if (master_off)
                    lvl_nxt[c*LVL_N +: LVL_N] = '0;
                else
                    lvl_nxt[c*LVL_N +: LVL_N] =
                        ((tgt_q == TGT_W'(c)) ? tgt_vec : '0) |
                        (LVL_N'(top_any) << (LVL_N - 1));
            end

            // R7
            bystander_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(tgt_q) != TGT_W'(c)) |->
                ((lvl_q[c*LVL_N +: LVL_N] & ~(LVL_N'(1) << (LVL_N - 1))) == '0));

            // R8
            top_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(|(pend_q & TOP)) && !$past(dis_q[MASTER_BIT])) |->
                lvl_q[c*LVL_N + LVL_N - 1]);

            // R2
            no_level0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !lvl_q[c*LVL_N]);
        end
    endgenerate

    // Output register presented to the per-processor blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_nxt;
    end

    // R9
    master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_q[MASTER_BIT]) |-> (lvl_q == '0));

endmodule

// File: rtl/irq_router.sv
// Top: multi-processor interrupt source router. Latches the device lines,
// holds the disable word and target number behind a five-word register
// window, and presents one registered level vector per processor.
// Assumes synchronous sources and a synchronous active-low reset.
module irq_router
    import irq_rt_pkg::*;
#(
    parameter int NCPU   = 16,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRC_N-1:0]      src_lvl,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [SRC_N-1:0]      bus_wdata,
    output logic [SRC_N-1:0]      bus_rdata,
    output logic [NCPU*LVL_N-1:0] cpu_lvl
);

    localparam int TGT_W = $clog2(NCPU);

    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] dis_q;
    logic [TGT_W-1:0] tgt_q;

    irq_src_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_lvl),
        .pend_q (pend_q)
    );

    irq_ctl_regs #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .pend_q (pend_q),
        .rdata  (bus_rdata),
        .dis_q  (dis_q),
        .tgt_q  (tgt_q)
    );

    irq_lvl_route #(.NCPU(NCPU)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_q (pend_q),
        .dis_q  (dis_q),
        .tgt_q  (tgt_q),
        .lvl_q  (cpu_lvl)
    );

endmodule

// File: tb/irq_router_test.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks per requirement. Inputs change 2 ns after a rising edge.
module irq_router_test;

    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   src_lvl = '0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC*16-1:0] cpu_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_lvl(cpu_lvl)
    );

    int tbl [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                     6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

    // Reference model state.
    bit [31:0] m_pend, m_dis;
    int        m_tgt;
    bit [15:0] m_out [NC];

    function automatic bit good_acc();
        return bus_req && bus_be == 4'hf && bus_addr[1:0] == 2'b00 && bus_addr < 5'd20;
    endfunction

    function automatic bit [31:0] model_read();
        if (!good_acc() || bus_we) return 0;
        case (bus_addr[4:2])
            3'd0: return m_pend & 32'h7fff_ffff;
            3'd1: return m_dis & 32'hf05d_ff80;
            3'd4: return 32'(m_tgt);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_dis = 32'h0fa2_007f; m_tgt = 0;
            for (int c = 0; c < NC; c++) m_out[c] = 0;
        end else begin
            bit top;
            top = 0;
            for (int j = 27; j <= 30; j++) if (m_pend[j]) top = 1;
            for (int c = 0; c < NC; c++) begin
                bit [15:0] v;
                v = 0;
                if (!m_dis[31]) begin
                    if (c == m_tgt)
                        for (int j = 0; j < 32; j++)
                            if (m_pend[j] && !m_dis[j] && tbl[j] != 0) v[tbl[j]] = 1;
                    if (top) v[15] = 1;
                end
                m_out[c] = v;
            end
            for (int j = 0; j < 32; j++) m_pend[j] = src_lvl[j] && tbl[j] != 0;
            if (good_acc() && bus_we) begin
                case (bus_addr[4:2])
                    3'd2: m_dis = m_dis & ~(bus_wdata & 32'hf05d_ff80);
                    3'd3: m_dis = m_dis | (bus_wdata & 32'hf05d_ff80);
                    3'd4: m_tgt = int'(bus_wdata[3:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] vec(input int c);
        return cpu_lvl[c*16 +: 16];
    endfunction

    // Every clock: all vectors and the read data against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NC; c++) chk("R7 model vector", 32'(vec(c)), 32'(m_out[c]));
            chk("R3 model read", bus_rdata, model_read());
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        step(1);
        bus_req = 0; bus_we = 0; bus_be = 0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [3:0] be,
                      input logic [31:0] exp);
        bus_req = 1; bus_we = 0; bus_addr = a; bus_be = be;
        #1;
        chk(tag, bus_rdata, exp);
        bus_req = 0; bus_be = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R10 reset state
        for (int c = 0; c < NC; c++) chk("R10 vector zero", 32'(vec(c)), 0);
        rd("R10 disable read", 5'h04, 4'hf, 32'h0);
        rd("R10 target read", 5'h10, 4'hf, 32'h0);
        rd("R10 pending read", 5'h00, 4'hf, 32'h0);

        // R1, R12 single source, then combinations
        src_lvl = 32'h1 << 7;
        step(1);
        chk("R12 not yet", 32'(vec(0)), 0);
        step(1);
        chk("R1 bit7 level2", 32'(vec(0)), 32'h0004);
        src_lvl = (32'h1 << 14) | (32'h1 << 20);
        step(2);
        chk("R1 bits14+20", 32'(vec(0)), 32'h1100);
        src_lvl = (32'h1 << 16) | (32'h1 << 18);
        step(2);
        chk("R1 bits16+18", 32'(vec(0)), 32'h0050);

        // R3, R2 pending read and dead sources
        src_lvl = (32'h1 << 7) | (32'h1 << 31) | (32'h1 << 24);
        step(1);
        rd("R3 pending read", 5'h00, 4'hf, 32'h0000_0080);
        step(1);
        chk("R2 dead sources", 32'(vec(0)), 32'h0004);

        // R6, R7 retarget
        wr(5'h10, 32'hffff_ff35, 4'hf);
        rd("R6 target read", 5'h10, 4'hf, 32'h5);
        step(1);
        chk("R7 new target", 32'(vec(5)), 32'h0004);
        chk("R7 old target", 32'(vec(0)), 32'h0);

        // R5, R4 disable and enable
        wr(5'h0c, 32'h80, 4'hf);
        rd("R4 disable read", 5'h04, 4'hf, 32'h80);
        step(1);
        chk("R5 disabled", 32'(vec(5)), 32'h0);
        wr(5'h08, 32'h80, 4'hf);
        step(1);
        chk("R5 re-enabled", 32'(vec(5)), 32'h0004);
        wr(5'h08, 32'h2, 4'hf);
        src_lvl = src_lvl | 32'h2;
        step(2);
        chk("R5 fixed bit stays", 32'(vec(5)), 32'h0004);
        rd("R5 fixed read", 5'h04, 4'hf, 32'h0);

        // R8 broadcast
        src_lvl = src_lvl | (32'h1 << 28);
        step(2);
        chk("R8 cpu0 top", 32'(vec(0)), 32'h8000);
        chk("R8 cpu5 top", 32'(vec(5)), 32'h8004);
        wr(5'h0c, 32'h1000_0000, 4'hf);
        rd("R4 bit28 read", 5'h04, 4'hf, 32'h1000_0000);
        step(1);
        chk("R8 disabled still", 32'(vec(15)), 32'h8000);

        // R9 master disable
        wr(5'h0c, 32'h8000_0000, 4'hf);
        step(1);
        for (int c = 0; c < NC; c++) chk("R9 quiet", 32'(vec(c)), 0);
        rd("R9 disable read", 5'h04, 4'hf, 32'h9000_0000);
        wr(5'h08, 32'h8000_0000, 4'hf);
        step(1);
        chk("R9 released", 32'(vec(5)), 32'h8004);

        // R11 invalid accesses
        wr(5'h10, 32'h2, 4'h3);
        rd("R11 partial write", 5'h10, 4'hf, 32'h5);
        wr(5'h11, 32'h2, 4'hf);
        rd("R11 misaligned write", 5'h10, 4'hf, 32'h5);
        wr(5'h0c, 32'h80, 4'h1);
        wr(5'h14, 32'hffff_ffff, 4'hf);
        rd("R11 partial disable", 5'h04, 4'hf, 32'h1000_0000);
        rd("R11 beyond window", 5'h14, 4'hf, 32'h0);
        rd("R11 partial read", 5'h00, 4'h7, 32'h0);
        rd("R11 misaligned read", 5'h01, 4'hf, 32'h0);
        step(1);
        chk("R11 vector unchanged", 32'(vec(5)), 32'h8004);

        step(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule